// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous requester and an 8K x 8 asynchronous static RAM. It accepts single read or write requests on a simple valid/busy interface and turns each one into a pin sequence on the memory side. The memory has two chip selects of opposite polarity, an active-low write strobe, an active-low read (output) strobe and a shared data bus. The data bus is split here into an output byte, an output-enable and an input byte, so that the pad or the board model can build the tri-state.

All timing is derived by counting clock cycles. Each minimum interval in nanoseconds is divided by the clock period parameter and rounded up to a whole number of cycles. The nanosecond limits are parameters of their own. The controller uses these counts to shape the address setup, the write pulse, the write recovery, the read access and the bus turnaround after a read. Read data comes back with a one-clock valid strobe. A busy flag stays high for the whole memory cycle.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is low and after it is released, mem_sel_n=1, mem_sel=0, mem_wr_n=1, mem_rd_n=1, mem_dq_oe=0, busy=0 and rd_valid=0.
- R2: A request is accepted only on a clock edge where req=1 and busy=0. A request presented while busy is high has no effect on the memory or on the timing of the cycle in progress.
- R3: The memory counts as selected only when mem_sel_n=0 and mem_sel=1. The controller always drives the two selects together, either both active or both inactive.
- R4: A read holds the selects active, mem_rd_n=0 and mem_wr_n=1 with a stable address for max(ceil(500/CLK_NS), ceil(500/CLK_NS)) cycles. The data bus is sampled on the edge that ends the last of these cycles, and rd_data returns the byte stored at req_addr.
- R5: A write first presents the address for ceil(100/CLK_NS) cycles with the selects inactive and mem_wr_n=1. The selects and mem_wr_n then assert on the same clock edge.
- R6: The write strobe stays low for max(ceil(150/CLK_NS), ceil(100/CLK_NS)) cycles. Write data is driven (mem_dq_oe=1) and unchanged for that whole time, so it is valid at least 100 ns before the strobe rises.
- R7: The address stays unchanged from acceptance until busy falls, which covers at least ceil(50/CLK_NS) cycles after the write strobe rises.
- R8: After a read, mem_dq_oe stays low for at least ceil(60/CLK_NS) cycles after mem_rd_n rises.
- R9: mem_rd_n is never low while mem_wr_n is low or while mem_dq_oe is high.
- R10: busy is high from the cycle after acceptance. For a read it lasts ceil(500/CLK_NS)+ceil(60/CLK_NS) cycles. For a write it lasts max(ceil(100/CLK_NS)+ceil(150/CLK_NS)+ceil(50/CLK_NS), ceil(500/CLK_NS)) cycles.
- R11: rd_valid is a single-cycle pulse, one per accepted read, and it is high in the cycle after the sampling edge, together with the captured rd_data.
- R12: Every cycle count is the nanosecond limit divided by CLK_NS and rounded up, including cases where the division is not exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Request valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Request address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Memory cycle in progress, requests ignored |
| rd_data | output | 8 | Captured read data |
| rd_valid | output | 1 | One-clock strobe for rd_data |
| mem_addr | output | 13 | Memory address pins |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low output enable |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Data bus as seen from the memory |

## Verification
The bench uses a clock period that does not divide the write pulse limit evenly. A controller that truncates instead of rounding up gives a strobe 2 ns short, and the memory model reports it. The memory model returns a corrupted byte until a full access time has passed, so a controller that samples even one cycle early returns the wrong byte. Requests injected while busy target a neighbouring address. A controller that accepts them either corrupts that byte or changes the busy length. Measuring the busy length catches a short recovery or a short turnaround that would otherwise go unseen.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the asynchronous SRAM cycle controller.
// Assumes all timing limits are positive whole nanoseconds.
package sram_ctrl_pkg;

    // Sequencer states; each memory cycle walks a fixed path through them.
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RD_ACCESS  = 3'd1,
        ST_RD_TURN    = 3'd2,
        ST_WR_SETUP   = 3'd3,
        ST_WR_PULSE   = 3'd4,
        ST_WR_RECOVER = 3'd5
    } state_e;

    // Nanoseconds to whole clock cycles, rounded up.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
// Cycle sequencer: one state register and one down-counter that holds each
// phase for its computed number of cycles. Assumes every count is >= 1.
module sram_seq
    import sram_ctrl_pkg::*;
#(
    parameter int N_AS    = 5,
    parameter int N_PULSE = 8,
    parameter int N_REC   = 12,
    parameter int N_RD    = 25,
    parameter int N_TURN  = 3,
    parameter int CNT_W   = 5
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req,
    input  logic   req_we,
    output state_e state_q,
    output state_e state_nxt,
    output logic   accept,
    output logic   sample,
    output logic   busy
);

    localparam logic [CNT_W-1:0] LD_AS    = CNT_W'(N_AS - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(N_PULSE - 1);
    localparam logic [CNT_W-1:0] LD_REC   = CNT_W'(N_REC - 1);
    localparam logic [CNT_W-1:0] LD_RD    = CNT_W'(N_RD - 1);
    localparam logic [CNT_W-1:0] LD_TURN  = CNT_W'(N_TURN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;
    logic             load;
    logic             cnt_done;

    assign cnt_done = (cnt_q == '0);
    assign busy     = (state_q != ST_IDLE);
    assign accept   = (state_q == ST_IDLE) && req;
    assign sample   = (state_q == ST_RD_ACCESS) && cnt_done;

    // Next-state and phase-length selection.
    always_comb begin
        state_nxt = state_q;
        load      = 1'b0;
        load_val  = '0;
        case (state_q)
            ST_IDLE: begin
                if (req) begin
                    load = 1'b1;
                    if (req_we) begin
                        state_nxt = ST_WR_SETUP;
                        load_val  = LD_AS;
                    end else begin
                        state_nxt = ST_RD_ACCESS;
                        load_val  = LD_RD;
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (cnt_done) begin
                    state_nxt = ST_RD_TURN;
                    load      = 1'b1;
                    load_val  = LD_TURN;
                end
            end
            ST_RD_TURN: begin
                if (cnt_done) state_nxt = ST_IDLE;
            end
            ST_WR_SETUP: begin
                if (cnt_done) begin
                    state_nxt = ST_WR_PULSE;
                    load      = 1'b1;
                    load_val  = LD_PULSE;
                end
            end
            ST_WR_PULSE: begin
                if (cnt_done) begin
                    state_nxt = ST_WR_RECOVER;
                    load      = 1'b1;
                    load_val  = LD_REC;
                end
            end
            ST_WR_RECOVER: begin
                if (cnt_done) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // Phase counter: load on phase entry, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (load)      cnt_q <= load_val;
        else if (!cnt_done) cnt_q <= cnt_q - 1'b1;
    end

endmodule

// File: rtl/sram_pin_drv.sv
`timescale 1ns/1ps
// Memory pin driver: every pin comes straight from a flop, loaded from the
// sequencer's next state, so the pins change in step with the state register
// and never glitch. Address and write data are latched when a request is
// accepted and held for the whole cycle.
module sram_pin_drv
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  state_e            state_nxt,
    input  logic              accept,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe
);

    logic sel_nxt;
    logic wr_nxt;
    logic rd_nxt;
    logic drv_nxt;

    // Pin decode of the coming state.
    always_comb begin
        wr_nxt  = (state_nxt == ST_WR_PULSE);
        rd_nxt  = (state_nxt == ST_RD_ACCESS);
        sel_nxt = wr_nxt || rd_nxt;
        drv_nxt = (state_nxt == ST_WR_PULSE) || (state_nxt == ST_WR_RECOVER);
    end

    // Control pin flops, all inactive in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_sel_n <= 1'b1;
            mem_sel   <= 1'b0;
            mem_wr_n  <= 1'b1;
            mem_rd_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_sel_n <= !sel_nxt;
            mem_sel   <= sel_nxt;
            mem_wr_n  <= !wr_nxt;
            mem_rd_n  <= !rd_nxt;
            mem_dq_oe <= drv_nxt;
        end
    end

    // Address and write data latches, loaded only on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_dq_o <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            if (req_we) mem_dq_o <= req_wdata;
        end
    end

endmodule

// File: rtl/sram_rd_cap.sv
`timescale 1ns/1ps
// Read capture: registers the memory data bus on the sampling edge and raises
// a one-clock valid strobe. Assumes the sequencer asserts sample only in the
// final access cycle of a read.
module sram_rd_cap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    // Valid strobe follows the sampling edge by exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= sample;
    end

    // Data register holds the last captured byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (sample) rd_data <= mem_dq_i;
    end

endmodule

// File: rtl/sram_cycle_ctrl.sv
`timescale 1ns/1ps
// Asynchronous SRAM cycle controller top. Converts single synchronous read or
// write requests into memory pin sequences whose phases are whole clock counts
// derived from nanosecond limits. Assumes the limits are given in ns and that
// CLK_NS is the true clock period.
module sram_cycle_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 20,
    parameter int T_RC_NS   = 500,
    parameter int T_AA_NS   = 500,
    parameter int T_WC_NS   = 500,
    parameter int T_AS_NS   = 100,
    parameter int T_WP_NS   = 150,
    parameter int T_DW_NS   = 100,
    parameter int T_WR_NS   = 50,
    parameter int T_OHZ_NS  = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int N_AS    = imax(1, ns_to_cyc(T_AS_NS, CLK_NS));
    localparam int N_WP    = imax(1, ns_to_cyc(T_WP_NS, CLK_NS));
    localparam int N_DW    = imax(1, ns_to_cyc(T_DW_NS, CLK_NS));
    localparam int N_WR    = imax(1, ns_to_cyc(T_WR_NS, CLK_NS));
    localparam int N_WC    = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int N_PULSE = imax(N_WP, N_DW);
    localparam int N_REC   = imax(N_WR, N_WC - N_AS - N_PULSE);
    localparam int N_RD    = imax(1, imax(ns_to_cyc(T_RC_NS, CLK_NS),
                                          ns_to_cyc(T_AA_NS, CLK_NS)));
    localparam int N_TURN  = imax(1, ns_to_cyc(T_OHZ_NS, CLK_NS));
    localparam int N_MAX   = imax(imax(N_AS, N_PULSE), imax(N_REC, imax(N_RD, N_TURN)));
    localparam int CNT_W   = $clog2(N_MAX + 1);

    state_e state_q;
    state_e state_nxt;
    logic   accept;
    logic   sample;

    sram_seq #(
        .N_AS    (N_AS),
        .N_PULSE (N_PULSE),
        .N_REC   (N_REC),
        .N_RD    (N_RD),
        .N_TURN  (N_TURN),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_we    (req_we),
        .state_q   (state_q),
        .state_nxt (state_nxt),
        .accept    (accept),
        .sample    (sample),
        .busy      (busy)
    );

    sram_pin_drv #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_nxt (state_nxt),
        .accept    (accept),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_addr  (mem_addr),
        .mem_sel_n (mem_sel_n),
        .mem_sel   (mem_sel),
        .mem_wr_n  (mem_wr_n),
        .mem_rd_n  (mem_rd_n),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe)
    );

    sram_rd_cap #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (sample),
        .mem_dq_i (mem_dq_i),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for the SRAM cycle controller pins. Interval lengths are
// checked with saturating counters, not long $past chains.
module sram_cycle_ctrl_chk #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter int N_AS   = 5,
    parameter int N_WP   = 8,
    parameter int N_OHZ  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_wr_n,
    input logic              mem_rd_n,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe
);

    logic [15:0]       stab_cnt;
    logic [15:0]       low_cnt;
    logic [15:0]       rdhi_cnt;
    logic [ADDR_W-1:0] addr_prev;

    // Cycles the address has held its value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stab_cnt  <= '0;
            addr_prev <= '0;
        end else begin
            addr_prev <= mem_addr;
            if (mem_addr != addr_prev) stab_cnt <= '0;
            else if (stab_cnt != 16'hFFFF) stab_cnt <= stab_cnt + 16'd1;
        end
    end

    // Cycles the write strobe has been low.
    always_ff @(posedge clk) begin
        if (!rst_n)         low_cnt <= '0;
        else if (mem_wr_n)  low_cnt <= '0;
        else if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 16'd1;
    end

    // Cycles since the output enable was last low.
    always_ff @(posedge clk) begin
        if (!rst_n)         rdhi_cnt <= 16'hFFFF;
        else if (!mem_rd_n) rdhi_cnt <= '0;
        else if (rdhi_cnt != 16'hFFFF) rdhi_cnt <= rdhi_cnt + 16'd1;
    end

    // R3
    sel_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel_n != mem_sel);

    // R9
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));

    // R9
    rd_drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_rd_n);

    // R5
    wr_sel_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_n) |-> $fell(mem_sel_n) && $rose(mem_sel));

    // R5
    addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_n) |-> (int'(stab_cnt) + 1 >= N_AS));

    // R6
    wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (int'(low_cnt) >= N_WP));

    // R6
    wr_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_n && $past(!mem_wr_n)) |-> ($stable(mem_dq_o) && mem_dq_oe));

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr));

    // R8
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (int'(rdhi_cnt) >= N_OHZ));

    // R11
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .N_AS   (N_AS),
    .N_WP   (N_WP),
    .N_OHZ  (N_TURN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_sel_n (mem_sel_n),
    .mem_sel   (mem_sel),
    .mem_wr_n  (mem_wr_n),
    .mem_rd_n  (mem_rd_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_cycle_ctrl_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task queues expected read bytes, and a monitor
// pops them when rd_valid is seen. A timed memory model checks the pin timing.
module sram_cycle_ctrl_bench;

    localparam int T = 4;

    function automatic int cdiv(input int ns);
        return (ns + T - 1) / T;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int EXP_RD_BUSY = cdiv(500) + cdiv(60);
    localparam int EXP_WR_BUSY = mx(cdiv(100) + cdiv(150) + cdiv(50), cdiv(500));

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [12:0] mem_addr;
    logic        mem_sel_n;
    logic        mem_sel;
    logic        mem_wr_n;
    logic        mem_rd_n;
    logic [7:0]  mem_dq_o;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_i = '0;

    int n_vec  = 0;
    int n_fail = 0;

    logic [7:0] model_mem  [int];
    logic [7:0] shadow_mem [int];
    logic [7:0] exp_q [$];

    always #(T/2) clk = ~clk;

    sram_cycle_ctrl #(.CLK_NS(T)) u_sram_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
        .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
        .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_wr_n(mem_wr_n),
        .mem_rd_n(mem_rd_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i)
    );

    function automatic logic [7:0] init_val(input int a);
        return 8'(a) ^ 8'(a >> 8) ^ 8'h3C;
    endfunction

    function automatic logic [7:0] model_rd(input int a);
        return model_mem.exists(a) ? model_mem[a] : init_val(a);
    endfunction

    function automatic logic [7:0] shadow_rd(input int a);
        return shadow_mem.exists(a) ? shadow_mem[a] : init_val(a);
    endfunction

    task automatic chk(input bit ok, input string req_tag, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req_tag, what, act, exp);
        end
    endtask

    // Memory model with timing checks, evaluated between clock edges.
    logic [12:0] pa = '0;
    logic [7:0]  pdq = '0;
    logic        poe = 1'b0;
    logic        pwr = 1'b0;
    logic        prd = 1'b0;
    int astab = 0, dlen = 0, wlen = 0, rlen = 0, rdhi = 1000;
    int wa = 0, wdlen = 0;
    logic [7:0] wd = '0;
    always @(negedge clk) begin
        bit sel, wr, rd;
        sel = !mem_sel_n && mem_sel;
        wr  = sel && !mem_wr_n;
        rd  = sel && !mem_rd_n && mem_wr_n;
        if (rst_n) begin
            astab = (mem_addr == pa) ? astab + 1 : 0;
            if (mem_dq_oe) dlen = (poe && mem_dq_o == pdq) ? dlen + 1 : 1;
            else           dlen = 0;
            if (wr && !pwr)
                chk(astab * T >= 100, "R5", "address setup ns", astab * T, 100);
            if (wr) begin
                wlen++; wa = int'(mem_addr); wd = mem_dq_o; wdlen = dlen;
            end
            if (!wr && pwr) begin
                chk(wlen * T >= 150, "R6", "write pulse ns", wlen * T, 150);
                chk(wdlen * T >= 100, "R6", "data setup ns", wdlen * T, 100);
                model_mem[wa] = wd;
                wlen = 0;
            end
            if (mem_dq_oe && !poe)
                chk(rdhi * T >= 60, "R8", "turnaround ns", rdhi * T, 60);
            rdhi = !mem_rd_n ? 0 : rdhi + 1;
            rlen = rd ? ((prd && mem_addr == pa) ? rlen + 1 : 1) : 0;
            mem_dq_i <= (rd && rlen * T >= 500) ? model_rd(int'(mem_addr))
                                                : ~model_rd(int'(mem_addr));
        end
        pa = mem_addr; pdq = mem_dq_o; poe = mem_dq_oe; pwr = wr; prd = rd;
    end

    // Scoreboard monitor.
    logic prev_rv = 1'b0;
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            chk(!prev_rv, "R11", "rd_valid width", 2, 1);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11", "unexpected rd_valid", 1, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R4", "read data", int'(rd_data), int'(e));
            end
        end
        prev_rv = rd_valid;
    end

    // Driver: one request, queue the expectation, measure busy.
    task automatic run_op(input bit w, input logic [12:0] a,
                          input logic [7:0] d, input bit inject);
        int len;
        @(negedge clk);
        while (busy) @(negedge clk);
        req = 1'b1; req_we = w; req_addr = a; req_wdata = d;
        if (w) shadow_mem[int'(a)] = d;
        else   exp_q.push_back(shadow_rd(int'(a)));
        @(negedge clk);
        req = 1'b0;
        len = 0;
        while (busy) begin
            len++;
            if (inject && len == 3) begin
                // R2: request while busy, must be dropped
                req = 1'b1; req_we = 1'b1; req_addr = a ^ 13'h1; req_wdata = 8'h99;
            end else begin
                req = 1'b0;
            end
            @(negedge clk);
        end
        req = 1'b0;
        chk(len == (w ? EXP_WR_BUSY : EXP_RD_BUSY), w ? "R10/R12" : "R10/R12",
            w ? "write busy cycles" : "read busy cycles", len,
            w ? EXP_WR_BUSY : EXP_RD_BUSY);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(mem_sel_n == 1'b1, "R1", "mem_sel_n", int'(mem_sel_n), 1);
        chk(mem_sel == 1'b0, "R1", "mem_sel", int'(mem_sel), 0);
        chk(mem_wr_n == 1'b1, "R1", "mem_wr_n", int'(mem_wr_n), 1);
        chk(mem_rd_n == 1'b1, "R1", "mem_rd_n", int'(mem_rd_n), 1);
        chk(mem_dq_oe == 1'b0, "R1", "mem_dq_oe", int'(mem_dq_oe), 0);
        chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
        chk(rd_valid == 1'b0, "R1", "rd_valid", int'(rd_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && mem_sel_n && mem_wr_n && mem_rd_n && !mem_dq_oe,
            "R1", "idle after release", int'(busy), 0);

        // R4: reads of initial content at both address ends
        run_op(1'b0, 13'd0, 8'h00, 1'b0);
        run_op(1'b0, 13'h1FFF, 8'h00, 1'b0);
        // R5/R6: writes with several patterns
        run_op(1'b1, 13'd0, 8'hFF, 1'b0);
        run_op(1'b1, 13'h1FFF, 8'h00, 1'b0);
        run_op(1'b1, 13'd100, 8'h55, 1'b0);
        run_op(1'b1, 13'd101, 8'hAA, 1'b0);
        run_op(1'b0, 13'd0, 8'h00, 1'b0);
        run_op(1'b0, 13'h1FFF, 8'h00, 1'b0);
        run_op(1'b0, 13'd100, 8'h00, 1'b0);
        run_op(1'b0, 13'd101, 8'h00, 1'b0);
        // R2: requests injected while busy are ignored
        run_op(1'b1, 13'd200, 8'h5A, 1'b1);
        run_op(1'b0, 13'd201, 8'h00, 1'b0);
        run_op(1'b0, 13'd200, 8'h00, 1'b0);
        run_op(1'b0, 13'd300, 8'h00, 1'b1);
        run_op(1'b0, 13'd301, 8'h00, 1'b0);
        // R8: write right after a read, then read back; overwrite
        run_op(1'b1, 13'd4095, 8'hC3, 1'b0);
        run_op(1'b0, 13'd4095, 8'h00, 1'b0);
        run_op(1'b1, 13'd100, 8'h0F, 1'b0);
        run_op(1'b0, 13'd100, 8'h00, 1'b0);

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R11", "reads outstanding", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule